// File: doc/BRIEF.md
# Light-Load Stage Shedding Controller

This block sets how many parallel power stages of one output rail run. It reads an averaged output-current value that arrives with a valid strobe. When shedding is enabled and the load falls below a programmable low limit, it switches off a programmable number of stages. When the load later rises above a separate high limit, it switches every stage back on. A current between the two limits keeps the present choice, so the gap between the limits acts as hysteresis.

Alongside the stage mask the block drives a one-bit coefficient-set select for the loop compensator. When the light-load swap flag is set, this select points to the light-load set while stages are shed, and it returns to the normal set when the stages are restored. Stages are removed from the top of the index range down, so stage 0 never switches off. A shed request that would remove every stage is limited so that one stage stays on.

Top module: `phase_shed_ctrl`

## Requirements
- R1: After reset all stage enables read 1 and `coef_sel_o` reads 0 (normal set).
- R2: With `en_i` high in the normal state, a valid sample strictly below `lim_lo_i` moves the block to light load on the next clock. `stage_en_o` then has its top E bits cleared, where E is the effective shed count. While in light load the mask follows the present `shed_cnt_i` one clock later.
- R3: In light load, a valid sample strictly above `lim_hi_i` restores all stages to 1 on the next clock.
- R4: A valid sample with `lim_lo_i <= sample <= lim_hi_i` leaves the state unchanged. A sample equal to either limit does not cause a transition.
- R5: While `sample_valid_i` is low, `sample_i` has no effect on the state.
- R6: With `en_i` low, the block is in the normal state on the next clock with all stages on and `coef_sel_o` at 0. Samples received while it is disabled are ignored.
- R7: `coef_sel_o` is 1 exactly when the registered state is light load and `coef_swap_en_i` was 1 on the previous clock. Otherwise it is 0.
- R8: The effective shed count is min(`shed_cnt_i`, N_STAGES-1), so bit 0 of `stage_en_o` is always 1.
- R9: Shedding removes the highest-numbered stages first. A shed count of 0 in light load keeps every stage on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Shedding enable; low forces the normal state |
| coef_swap_en_i | input | 1 | Allows selection of the light-load coefficient set |
| sample_valid_i | input | 1 | Strobe qualifying `sample_i` |
| sample_i | input | CUR_W | Averaged output current, unsigned |
| lim_lo_i | input | CUR_W | Enter-light-load limit |
| lim_hi_i | input | CUR_W | Leave-light-load limit |
| shed_cnt_i | input | CNT_W | Number of stages to switch off in light load |
| stage_en_o | output | N_STAGES | Per-stage enable, bit 0 = first stage |
| coef_sel_o | output | 1 | 0 = normal coefficients, 1 = light-load coefficients |

## Verification
The bench uses N_STAGES=4, CUR_W=12 and CNT_W=3. With these values shed counts from 0 to 7 can be applied. Counts of 3 and above reach the clamp and leave only stage 0 running, and every mask shape from one stage to four can be observed. A 12-bit sample lets the bench place values exactly on each limit and one step outside it. It also drives samples without the valid strobe and samples while the block is disabled.

// File: rtl/phase_shed_pkg.sv
package phase_shed_pkg;
    typedef enum logic {
        ST_NORMAL = 1'b0,
        ST_LIGHT  = 1'b1
    } shed_state_e;
endpackage

// File: rtl/shed_mask_gen.sv
module shed_mask_gen #(
    parameter int N_STAGES = 4,
    parameter int CNT_W    = 3
) (
    input  logic [CNT_W-1:0]    shed_cnt_i,
    input  logic                light_i,
    output logic [N_STAGES-1:0] mask_o
);
    localparam int MAX_SHED = N_STAGES - 1;

    logic [CNT_W-1:0] eff_cnt;

    // Clamp so at least one stage survives
    always_comb begin
        if (int'(shed_cnt_i) > MAX_SHED) eff_cnt = CNT_W'(MAX_SHED);
        else                             eff_cnt = shed_cnt_i;
    end

    // Highest-numbered stages drop first
    for (genvar g = 0; g < N_STAGES; g++) begin : g_stage
        assign mask_o[g] = !light_i || (g < (N_STAGES - int'(eff_cnt)));
    end
endmodule

// File: rtl/shed_fsm.sv
module shed_fsm
    import phase_shed_pkg::*;
#(
    parameter int CUR_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             valid_i,
    input  logic [CUR_W-1:0] sample_i,
    input  logic [CUR_W-1:0] lim_lo_i,
    input  logic [CUR_W-1:0] lim_hi_i,
    output shed_state_e      state_d_o,
    output shed_state_e      state_q_o
);
    shed_state_e state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (!en_i) begin
            state_d = ST_NORMAL;
        end else if (valid_i) begin
            case (state_q)
                ST_NORMAL: if (sample_i < lim_lo_i) state_d = ST_LIGHT;
                ST_LIGHT:  if (sample_i > lim_hi_i) state_d = ST_NORMAL;
                default:   state_d = ST_NORMAL;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_NORMAL;
        else        state_q <= state_d;
    end

    assign state_d_o = state_d;
    assign state_q_o = state_q;

    // R2
    shed_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_i && valid_i && state_q == ST_NORMAL && sample_i < lim_lo_i |=> state_q == ST_LIGHT);

    // R4
    hold_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_i && valid_i && sample_i >= lim_lo_i && sample_i <= lim_hi_i |=> $stable(state_q));

    // R5
    no_valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_i && !valid_i |=> $stable(state_q));
endmodule

// File: rtl/phase_shed_ctrl.sv
module phase_shed_ctrl
    import phase_shed_pkg::*;
#(
    parameter int N_STAGES = 4,
    parameter int CUR_W    = 12,
    parameter int CNT_W    = $clog2(N_STAGES + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en_i,
    input  logic                coef_swap_en_i,
    input  logic                sample_valid_i,
    input  logic [CUR_W-1:0]    sample_i,
    input  logic [CUR_W-1:0]    lim_lo_i,
    input  logic [CUR_W-1:0]    lim_hi_i,
    input  logic [CNT_W-1:0]    shed_cnt_i,
    output logic [N_STAGES-1:0] stage_en_o,
    output logic                coef_sel_o
);
    localparam logic [N_STAGES-1:0] ALL_ON = '1;

    typedef struct packed {
        logic [N_STAGES-1:0] mask;
        logic                coef;
    } out_t;

    shed_state_e         state_d, state_q;
    logic [N_STAGES-1:0] mask_next;
    out_t                out_d, out_q;

    shed_fsm #(.CUR_W(CUR_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en_i),
        .valid_i   (sample_valid_i),
        .sample_i  (sample_i),
        .lim_lo_i  (lim_lo_i),
        .lim_hi_i  (lim_hi_i),
        .state_d_o (state_d),
        .state_q_o (state_q)
    );

    shed_mask_gen #(.N_STAGES(N_STAGES), .CNT_W(CNT_W)) u_mask (
        .shed_cnt_i (shed_cnt_i),
        .light_i    (state_d == ST_LIGHT),
        .mask_o     (mask_next)
    );

    always_comb begin
        out_d      = out_q;
        out_d.mask = mask_next;
        out_d.coef = (state_d == ST_LIGHT) && coef_swap_en_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '{mask: ALL_ON, coef: 1'b0};
        else        out_q <= out_d;
    end

    assign stage_en_o = out_q.mask;
    assign coef_sel_o = out_q.coef;

    // R6
    disable_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (stage_en_o == ALL_ON) && !coef_sel_o);

    // R7
    coef_light_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        coef_sel_o |-> state_q == ST_LIGHT);

    // R3
    normal_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_NORMAL |-> stage_en_o == ALL_ON);

    // R8
    one_stage_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_LIGHT |-> stage_en_o[0]);
endmodule

// File: tb/tb_phase_shed_ctrl.sv
module tb_phase_shed_ctrl;
    localparam int N  = 4;
    localparam int CW = 12;
    localparam int KW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0, swap = 1'b0, vld = 1'b0;
    logic [CW-1:0] smp = '0, lo = 12'd100, hi = 12'd200;
    logic [KW-1:0] shed = '0;
    logic [N-1:0]  stage_en;
    logic          coef_sel;

    int tests = 0;
    int fails = 0;
    bit model_light = 1'b0;
    bit done = 1'b0;

    typedef struct {
        logic [N-1:0] mask;
        logic         coef;
        string        tag;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    phase_shed_ctrl #(.N_STAGES(N), .CUR_W(CW), .CNT_W(KW)) dut (
        .clk(clk), .rst_n(rst_n), .en_i(en), .coef_swap_en_i(swap),
        .sample_valid_i(vld), .sample_i(smp), .lim_lo_i(lo), .lim_hi_i(hi),
        .shed_cnt_i(shed), .stage_en_o(stage_en), .coef_sel_o(coef_sel)
    );

    task automatic step(input bit e, input bit sw, input bit v, input int s,
                        input int k, input string tag);
        exp_t it;
        int eff;
        @(negedge clk);
        en = e; swap = sw; vld = v; smp = CW'(s); shed = KW'(k);
        if (!e) model_light = 1'b0;
        else if (v) begin
            if (!model_light && s < int'(lo)) model_light = 1'b1;
            else if (model_light && s > int'(hi)) model_light = 1'b0;
        end
        eff = (k > N - 1) ? N - 1 : k;
        it.mask = model_light ? N'((1 << (N - eff)) - 1) : {N{1'b1}};
        it.coef = model_light && sw;
        it.tag  = tag;
        sb.push_back(it);
        @(posedge clk);
    endtask

    initial begin : monitor
        exp_t it;
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                it = sb.pop_front();
                tests++;
                if (stage_en !== it.mask || coef_sel !== it.coef) begin
                    fails++;
                    $display("FAIL %s: got mask=%b coef=%b, expected mask=%b coef=%b",
                             it.tag, stage_en, coef_sel, it.mask, it.coef);
                end
            end
        end
    end

    initial begin : watchdog
        #(4 * 20000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        tests++;
        if (stage_en !== 4'b1111 || coef_sel !== 1'b0) begin
            fails++;
            $display("FAIL R1: got mask=%b coef=%b, expected 1111 0", stage_en, coef_sel);
        end
        @(negedge clk); rst_n = 1'b1;
        step(1, 1, 1, 150, 2, "R4 mid band normal");
        step(1, 1, 1, 100, 2, "R4 equal low limit");
        step(1, 1, 0,  99, 2, "R5 no valid");
        step(1, 1, 1,  99, 2, "R2 shed two");
        step(1, 1, 1, 200, 2, "R4 equal high limit");
        step(1, 1, 1, 150, 2, "R4 mid band light");
        step(1, 1, 0, 150, 1, "R9 shed one top stage");
        step(1, 1, 0, 900, 1, "R5 high without valid");
        step(1, 1, 1, 201, 1, "R3 restore all");
        step(1, 0, 1,  50, 1, "R7 no swap in light");
        step(1, 0, 0,  50, 4, "R8 clamp at four");
        step(1, 0, 0,  50, 7, "R8 clamp at seven");
        step(1, 0, 0,  50, 3, "R8 clamp at three");
        step(1, 1, 0,  50, 0, "R9 shed zero");
        step(1, 1, 0,  50, 2, "R7 swap in light");
        step(0, 1, 0,  50, 2, "R6 disable forces normal");
        step(0, 1, 1,  10, 2, "R6 sample ignored");
        step(1, 1, 1, 300, 2, "R3 high in normal");
        step(1, 1, 1,  10, 3, "R2 shed three");
        step(1, 1, 1,   0, 3, "R4 still light");
        step(1, 1, 1, 4095, 3, "R3 max sample restores");
        step(1, 1, 1, 0, 2, "R2 zero sample sheds");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule